// File: doc/BRIEF.md
# Exception Entry and Return Controller

This block holds the privilege state of a simplified 64-bit core: the current exception level, the stack-select bit and the four interrupt mask bits. It decides when an exception is taken and computes the handler address. It also saves the context needed to come back and carries out the exception return. Only one target level, level 1, has its own link, syndrome, saved-state and vector-base registers.

Each cycle the block looks at several inputs: the synchronous exception strobe, the three asynchronous request lines, the return strobe, the mask set/clear commands and a context write port. Software uses the context write port to prepare a return into a new thread. When an exception is taken or a legal return happens, the block raises `redirect_valid` for one cycle. `redirect_pc` then holds the fetch address, which is the handler address or the saved link address. A return that would raise the level is refused: `illegal_ret` pulses and no state changes. All results appear one clock after the stimulus.

Top module: `priv_trap_ctrl`

## Requirements
- R1: After reset the block shows level 1, stack select 1 and all four mask bits set (mask_bits = 4'hF). Link, syndrome, saved state and vector base are zero, and redirect_valid and illegal_ret are low.
- R2: The handler address is vector base + source row + kind column. The kind columns are synchronous 0x000, IRQ 0x080, FIQ 0x100 and SError 0x180. Every handler address is a multiple of 0x80.
- R3: The source row is taken from the state before entry. At level 1 it is 0x000 with stack select 0 and 0x200 with stack select 1. At level 0 it is 0x400 when el0_narrow is 0 and 0x600 when el0_narrow is 1.
- R4: A vector-base write stores the data with bits [10:0] forced to zero. Entries in later cycles use the new base.
- R5: A synchronous strobe is always taken, even with all masks set. Among unmasked asynchronous requests the order is SError, then FIQ, then IRQ. mask_bits bit 0 is D (blocks nothing here), bit 1 is A (SError), bit 2 is I (IRQ) and bit 3 is F (FIQ).
- R6: An asynchronous request whose mask bit is set is ignored: no redirect and no change to any output.
- R7: On entry, the link register gets pc_in and saved_state gets the pre-entry {mask[3:0], stack select, level[1:0]} in bits [6:3], [2] and [1:0]. The level is raised to 1 and stack select becomes 1. All four mask bits are set, and the redirect appears in the next cycle.
- R8: The syndrome register loads cause_in only for a synchronous exception or an SError. IRQ and FIQ leave it unchanged.
- R9: A mask set command ORs mask_imm into the mask bits and a clear command removes them. If both come in the same cycle, only the set applies. Both are ignored in a cycle with an entry or an exception return.
- R10: A legal return restores the level, stack select and mask bits from saved_state and redirects to the link address. It then clears the link and saved_state to zero. A return to the same level is legal.
- R11: A return whose saved level is above the current level is illegal. illegal_ret pulses for one cycle, there is no redirect, and the level, masks, link and saved state stay as they were.
- R12: A context write loads the link and saved_state. It is ignored in a cycle with an entry or an exception return strobe.
- R13: The level changes only in the cycle after an entry or a legal return.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| sync_req | input | 1 | Synchronous exception strobe |
| cause_in | input | CAUSE_W | Syndrome value for synchronous or SError entry |
| irq_req | input | 1 | Pending normal interrupt (level) |
| fiq_req | input | 1 | Pending fast interrupt (level) |
| serr_req | input | 1 | Pending system error (level) |
| pc_in | input | ADDR_W | Address of the current instruction |
| el0_narrow | input | 1 | Level 0 runs in 32-bit state |
| eret_req | input | 1 | Exception return strobe |
| mask_set_req | input | 1 | Set mask bits given by mask_imm |
| mask_clr_req | input | 1 | Clear mask bits given by mask_imm |
| mask_imm | input | 4 | Mask select: bit0 D, bit1 A, bit2 I, bit3 F |
| vbar_wr_en | input | 1 | Vector base write strobe |
| vbar_wr_data | input | ADDR_W | Vector base write value |
| ctx_wr_en | input | 1 | Context write strobe |
| ctx_wr_link | input | ADDR_W | Link value for context write |
| ctx_wr_state | input | 7 | Saved-state value for context write |
| cur_el | output | 2 | Current exception level |
| sp_sel | output | 1 | Current stack select |
| mask_bits | output | 4 | Current masks, same bit order as mask_imm |
| redirect_valid | output | 1 | One-cycle fetch redirect |
| redirect_pc | output | ADDR_W | Redirect target |
| link_reg | output | ADDR_W | Saved return address |
| syndrome_reg | output | CAUSE_W | Saved exception cause |
| saved_state | output | 7 | Saved {mask, stack select, level} |
| illegal_ret | output | 1 | One-cycle illegal-return flag |

## Verification
The bound checker watches every cycle for several rules: entry always sets all masks and produces a redirect aligned to 0x80, the level never moves outside entries and legal returns, and a return never raises the level. It also checks that an illegal return pulses the flag without a redirect, and that any taken interrupt had its mask bit clear. Only the bench scenarios can show the exact handler offsets for each source row and kind column. The same holds for the arbitration order between simultaneous requests and for the set-wins rule of the mask commands. The bench scenarios also cover syndrome selectivity, the zeroing of context on return, and the dropping of context writes and mask commands that arrive together with an entry or a return.

// File: rtl/priv_trap_pkg.sv
// Shared types and constants for the exception entry/return controller.
// Assumes one handler target level (level 1) and a 16-slot vector table.
package priv_trap_pkg;
    // Kind order equals the column order of the vector table.
    typedef enum logic [1:0] {TK_SYNC = 2'd0, TK_IRQ = 2'd1, TK_FIQ = 2'd2, TK_SERR = 2'd3} trap_kind_e;
    // Source order equals the row order of the vector table.
    typedef enum logic [1:0] {SRC_CUR_SP0 = 2'd0, SRC_CUR_SPX = 2'd1, SRC_LOW_W64 = 2'd2, SRC_LOW_W32 = 2'd3} trap_src_e;

    typedef struct packed {
        logic [3:0] daif;
        logic       sp_sel;
        logic [1:0] el;
    } pstate_t;

    localparam int PSTATE_W    = $bits(pstate_t);
    localparam int SLOT_SHIFT  = 7;               // 0x80 bytes per slot
    localparam int ROW_SHIFT   = SLOT_SHIFT + 2;  // four slots per row
    localparam int TABLE_SHIFT = ROW_SHIFT + 2;   // four rows per table
    localparam int MB_A = 1;
    localparam int MB_I = 2;
    localparam int MB_F = 3;
    localparam logic [1:0] EL_TARGET = 2'd1;
    localparam pstate_t PSTATE_RESET = '{daif: 4'hF, sp_sel: 1'b1, el: EL_TARGET};
endpackage

// File: rtl/trap_select.sv
// Picks the exception to take this cycle.
// Assumes level-sensitive asynchronous requests; masks come from current state.
module trap_select
    import priv_trap_pkg::*;
(
    input  logic       sync_req,
    input  logic       serr_req,
    input  logic       fiq_req,
    input  logic       irq_req,
    input  logic [3:0] mask_bits,
    output logic       take,
    output trap_kind_e kind
);
    logic serr_ok, fiq_ok, irq_ok;

    // Qualify requests by mask and resolve priority: sync, SError, FIQ, IRQ.
    always_comb begin
        serr_ok = serr_req && !mask_bits[MB_A];
        fiq_ok  = fiq_req  && !mask_bits[MB_F];
        irq_ok  = irq_req  && !mask_bits[MB_I];
        take    = sync_req || serr_ok || fiq_ok || irq_ok;
        if (sync_req)     kind = TK_SYNC;
        else if (serr_ok) kind = TK_SERR;
        else if (fiq_ok)  kind = TK_FIQ;
        else              kind = TK_IRQ;
    end
endmodule

// File: rtl/trap_vector.sv
// Forms the handler address from base, source row and kind column.
// Assumes the base is aligned to the table size.
module trap_vector
    import priv_trap_pkg::*;
#(
    parameter int ADDR_W = 32
) (
    input  logic [ADDR_W-1:0] base,
    input  trap_kind_e        kind,
    input  trap_src_e         src,
    output logic [ADDR_W-1:0] handler
);
    localparam int PAD_W = ADDR_W - 2;

    // Sum of base, row offset and column offset.
    always_comb begin
        handler = base
                + ({{PAD_W{1'b0}}, src}  << ROW_SHIFT)
                + ({{PAD_W{1'b0}}, kind} << SLOT_SHIFT);
    end
endmodule

// File: rtl/trap_mask_unit.sv
// Next-value logic for the four mask bits.
// Assumes entry beats return, and return beats software commands.
module trap_mask_unit (
    input  logic       take,
    input  logic       eret_req,
    input  logic       ret_ok,
    input  logic [3:0] cur_mask,
    input  logic [3:0] saved_mask,
    input  logic       set_req,
    input  logic       clr_req,
    input  logic [3:0] imm,
    output logic [3:0] next_mask
);
    // Select the mask source in priority order.
    always_comb begin
        if (take)          next_mask = 4'hF;
        else if (ret_ok)   next_mask = saved_mask;
        else if (eret_req) next_mask = cur_mask;
        else if (set_req)  next_mask = cur_mask | imm;
        else if (clr_req)  next_mask = cur_mask & ~imm;
        else               next_mask = cur_mask;
    end
endmodule

// File: rtl/priv_trap_ctrl.sv
// Exception entry and return controller for target level 1.
// Holds level, stack select, masks, link, syndrome, saved state and vector
// base; all outputs are registered and follow the stimulus by one clock.
module priv_trap_ctrl
    import priv_trap_pkg::*;
#(
    parameter int ADDR_W  = 32,
    parameter int CAUSE_W = 16
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                sync_req,
    input  logic [CAUSE_W-1:0]  cause_in,
    input  logic                irq_req,
    input  logic                fiq_req,
    input  logic                serr_req,
    input  logic [ADDR_W-1:0]   pc_in,
    input  logic                el0_narrow,
    input  logic                eret_req,
    input  logic                mask_set_req,
    input  logic                mask_clr_req,
    input  logic [3:0]          mask_imm,
    input  logic                vbar_wr_en,
    input  logic [ADDR_W-1:0]   vbar_wr_data,
    input  logic                ctx_wr_en,
    input  logic [ADDR_W-1:0]   ctx_wr_link,
    input  logic [PSTATE_W-1:0] ctx_wr_state,
    output logic [1:0]          cur_el,
    output logic                sp_sel,
    output logic [3:0]          mask_bits,
    output logic                redirect_valid,
    output logic [ADDR_W-1:0]   redirect_pc,
    output logic [ADDR_W-1:0]   link_reg,
    output logic [CAUSE_W-1:0]  syndrome_reg,
    output logic [PSTATE_W-1:0] saved_state,
    output logic                illegal_ret
);
    localparam logic [ADDR_W-1:0] BASE_LOW_MASK = (ADDR_W'(1) << TABLE_SHIFT) - ADDR_W'(1);

    pstate_t            cur_q, saved_q;
    logic [ADDR_W-1:0]  link_q, vbar_q, rpc_q;
    logic [CAUSE_W-1:0] syn_q;
    logic               rv_q, ill_q;
    logic               take_now, ret_ok, ret_bad, ctx_ok;
    trap_kind_e         take_kind;
    trap_src_e          src_state;
    logic [ADDR_W-1:0]  handler_pc;
    logic [3:0]         mask_next;

    trap_select u_sel (
        .sync_req (sync_req),
        .serr_req (serr_req),
        .fiq_req  (fiq_req),
        .irq_req  (irq_req),
        .mask_bits(cur_q.daif),
        .take     (take_now),
        .kind     (take_kind)
    );

    // Source row from the pre-entry level and stack select.
    always_comb begin
        if (cur_q.el < EL_TARGET) src_state = el0_narrow ? SRC_LOW_W32 : SRC_LOW_W64;
        else                      src_state = cur_q.sp_sel ? SRC_CUR_SPX : SRC_CUR_SP0;
    end

    trap_vector #(.ADDR_W(ADDR_W)) u_vec (
        .base   (vbar_q),
        .kind   (take_kind),
        .src    (src_state),
        .handler(handler_pc)
    );

    // Classify the return and qualify the context write.
    always_comb begin
        ret_ok  = eret_req && !take_now && (saved_q.el <= cur_q.el);
        ret_bad = eret_req && !take_now && (saved_q.el >  cur_q.el);
        ctx_ok  = ctx_wr_en && !take_now && !eret_req;
    end

    trap_mask_unit u_mask (
        .take      (take_now),
        .eret_req  (eret_req),
        .ret_ok    (ret_ok),
        .cur_mask  (cur_q.daif),
        .saved_mask(saved_q.daif),
        .set_req   (mask_set_req),
        .clr_req   (mask_clr_req),
        .imm       (mask_imm),
        .next_mask (mask_next)
    );

    // Current processor state: level, stack select and masks.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cur_q <= PSTATE_RESET;
        end else begin
            cur_q.daif <= mask_next;
            if (take_now) begin
                cur_q.el     <= (cur_q.el < EL_TARGET) ? EL_TARGET : cur_q.el;
                cur_q.sp_sel <= 1'b1;
            end else if (ret_ok) begin
                cur_q.el     <= saved_q.el;
                cur_q.sp_sel <= saved_q.sp_sel;
            end
        end
    end

    // Link and saved-state registers.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            link_q  <= '0;
            saved_q <= '0;
        end else if (take_now) begin
            link_q  <= pc_in;
            saved_q <= cur_q;
        end else if (ret_ok) begin
            link_q  <= '0;
            saved_q <= '0;
        end else if (ctx_ok) begin
            link_q  <= ctx_wr_link;
            saved_q <= pstate_t'(ctx_wr_state);
        end
    end

    // Syndrome capture for synchronous and SError entries.
    always_ff @(posedge clk) begin
        if (!rst_n)
            syn_q <= '0;
        else if (take_now && (take_kind == TK_SYNC || take_kind == TK_SERR))
            syn_q <= cause_in;
    end

    // Vector base register with table alignment enforced.
    always_ff @(posedge clk) begin
        if (!rst_n)          vbar_q <= '0;
        else if (vbar_wr_en) vbar_q <= vbar_wr_data & ~BASE_LOW_MASK;
    end

    // Redirect and illegal-return outputs.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rv_q  <= 1'b0;
            rpc_q <= '0;
            ill_q <= 1'b0;
        end else begin
            rv_q  <= take_now || ret_ok;
            ill_q <= ret_bad;
            if (take_now)    rpc_q <= handler_pc;
            else if (ret_ok) rpc_q <= link_q;
        end
    end

    assign cur_el         = cur_q.el;
    assign sp_sel         = cur_q.sp_sel;
    assign mask_bits      = cur_q.daif;
    assign redirect_valid = rv_q;
    assign redirect_pc    = rpc_q;
    assign link_reg       = link_q;
    assign syndrome_reg   = syn_q;
    assign saved_state    = saved_q;
    assign illegal_ret    = ill_q;
endmodule

// File: rtl/priv_trap_ctrl_chk.sv
// Cycle-by-cycle rules of the controller, bound to its internal decisions.
// Assumes the port names of priv_trap_ctrl.
module priv_trap_ctrl_chk #(
    parameter int ADDR_W = 32
) (
    input logic              clk,
    input logic              rst_n,
    input logic              take_now,
    input logic              ret_ok,
    input logic              ret_bad,
    input logic              sync_req,
    input logic [1:0]        take_kind,
    input logic [1:0]        cur_el,
    input logic [3:0]        mask_bits,
    input logic              redirect_valid,
    input logic [ADDR_W-1:0] redirect_pc,
    input logic              illegal_ret
);
    a_r7_entry_masks: assert property (@(posedge clk) disable iff (!rst_n)
        take_now |=> mask_bits == 4'hF);

    a_r2_entry_aligned: assert property (@(posedge clk) disable iff (!rst_n)
        take_now |=> redirect_valid && redirect_pc[6:0] == 7'd0);

    a_r7_entry_level: assert property (@(posedge clk) disable iff (!rst_n)
        take_now |=> cur_el >= 2'd1);

    a_r13_level_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !take_now && !ret_ok |=> $stable(cur_el));

    a_r10_no_raise: assert property (@(posedge clk) disable iff (!rst_n)
        ret_ok |=> cur_el <= $past(cur_el));

    a_r11_illegal_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        ret_bad |=> illegal_ret && !redirect_valid && $stable(cur_el));

    a_r11_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
        !(illegal_ret && redirect_valid));

    a_r5_irq_unmasked: assert property (@(posedge clk) disable iff (!rst_n)
        take_now && !sync_req && take_kind == 2'd1 |-> !mask_bits[2]);

    a_r5_fiq_unmasked: assert property (@(posedge clk) disable iff (!rst_n)
        take_now && !sync_req && take_kind == 2'd2 |-> !mask_bits[3]);

    a_r5_serr_unmasked: assert property (@(posedge clk) disable iff (!rst_n)
        take_now && !sync_req && take_kind == 2'd3 |-> !mask_bits[1]);
endmodule

bind priv_trap_ctrl priv_trap_ctrl_chk #(.ADDR_W(ADDR_W)) u_chk (
    .clk           (clk),
    .rst_n         (rst_n),
    .take_now      (take_now),
    .ret_ok        (ret_ok),
    .ret_bad       (ret_bad),
    .sync_req      (sync_req),
    .take_kind     (take_kind),
    .cur_el        (cur_el),
    .mask_bits     (mask_bits),
    .redirect_valid(redirect_valid),
    .redirect_pc   (redirect_pc),
    .illegal_ret   (illegal_ret)
);

// File: tb/priv_trap_ctrl_test.sv
module priv_trap_ctrl_test;
    localparam int AW = 32;
    localparam int CW = 16;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic sync_req = 0, irq_req = 0, fiq_req = 0, serr_req = 0, el0_narrow = 0, eret_req = 0;
    logic mask_set_req = 0, mask_clr_req = 0, vbar_wr_en = 0, ctx_wr_en = 0;
    logic [CW-1:0] cause_in = '0;
    logic [AW-1:0] pc_in = '0, vbar_wr_data = '0, ctx_wr_link = '0;
    logic [3:0] mask_imm = '0;
    logic [6:0] ctx_wr_state = '0;
    logic [1:0] cur_el;
    logic sp_sel, redirect_valid, illegal_ret;
    logic [3:0] mask_bits;
    logic [AW-1:0] redirect_pc, link_reg;
    logic [CW-1:0] syndrome_reg;
    logic [6:0] saved_state;

    always #4 clk = ~clk;

    priv_trap_ctrl #(.ADDR_W(AW), .CAUSE_W(CW)) uut (.*);

    typedef struct {
        string tag;
        logic [1:0] el; logic sp; logic [3:0] msk; logic rv; logic [AW-1:0] rpc;
        logic [AW-1:0] link; logic [CW-1:0] syn; logic [6:0] saved; logic ill;
    } exp_t;
    exp_t q[$];

    int n_cmp = 0, n_bad = 0;
    bit done = 0;

    // Reference state, built from the requirements.
    logic [1:0] m_el = 2'd1; logic m_sp = 1'b1; logic [3:0] m_msk = 4'hF;
    logic [AW-1:0] m_link = '0, m_vbar = '0, m_rpc = '0; logic [CW-1:0] m_syn = '0;
    logic [6:0] m_saved = '0;

    task automatic predict(input string tag);
        exp_t e;
        logic t_s, t_e, t_f, t_i, rv, ill;
        logic [AW-1:0] col, row;
        t_s = sync_req;
        t_e = !t_s && serr_req && !m_msk[1];
        t_f = !t_s && !t_e && fiq_req && !m_msk[3];
        t_i = !t_s && !t_e && !t_f && irq_req && !m_msk[2];
        rv = 0; ill = 0;
        if (t_s || t_e || t_f || t_i) begin
            col = t_s ? 32'h000 : t_i ? 32'h080 : t_f ? 32'h100 : 32'h180;
            row = (m_el == 2'd0) ? (el0_narrow ? 32'h600 : 32'h400) : (m_sp ? 32'h200 : 32'h000);
            rv = 1; m_rpc = m_vbar + row + col;
            m_link = pc_in;
            if (t_s || t_e) m_syn = cause_in;
            m_saved = {m_msk, m_sp, m_el};
            if (m_el == 2'd0) m_el = 2'd1;
            m_sp = 1'b1; m_msk = 4'hF;
        end else if (eret_req) begin
            if (m_saved[1:0] > m_el) ill = 1;
            else begin
                rv = 1; m_rpc = m_link;
                m_el = m_saved[1:0]; m_sp = m_saved[2]; m_msk = m_saved[6:3];
                m_link = '0; m_saved = '0;
            end
        end else begin
            if (mask_set_req) m_msk = m_msk | mask_imm;
            else if (mask_clr_req) m_msk = m_msk & ~mask_imm;
            if (ctx_wr_en) begin m_link = ctx_wr_link; m_saved = ctx_wr_state; end
        end
        if (vbar_wr_en) m_vbar = {vbar_wr_data[AW-1:11], 11'd0};
        e.tag = tag; e.el = m_el; e.sp = m_sp; e.msk = m_msk; e.rv = rv; e.rpc = m_rpc;
        e.link = m_link; e.syn = m_syn; e.saved = m_saved; e.ill = ill;
        q.push_back(e);
    endtask

    // Driver: predict, let one edge pass, then drop the strobes.
    task automatic tick(input string tag);
        predict(tag);
        @(posedge clk);
        @(negedge clk);
        sync_req = 0; eret_req = 0; mask_set_req = 0; mask_clr_req = 0;
        vbar_wr_en = 0; ctx_wr_en = 0;
    endtask

    task automatic chk(input string tag, input string f, input logic [AW-1:0] act,
                       input logic [AW-1:0] exp, inout bit bad);
        if (act !== exp) begin
            $display("FAIL %s %s: actual %h expected %h", tag, f, act, exp);
            bad = 1;
        end
    endtask

    // Monitor: pop one expectation per edge and compare away from the edge.
    initial begin
        forever begin
            @(posedge clk);
            #2;
            if (q.size() > 0) begin
                exp_t e;
                bit bad;
                e = q.pop_front();
                bad = 0;
                chk(e.tag, "cur_el", AW'(cur_el), AW'(e.el), bad);
                chk(e.tag, "sp_sel", AW'(sp_sel), AW'(e.sp), bad);
                chk(e.tag, "mask_bits", AW'(mask_bits), AW'(e.msk), bad);
                chk(e.tag, "redirect_valid", AW'(redirect_valid), AW'(e.rv), bad);
                if (e.rv) chk(e.tag, "redirect_pc", redirect_pc, e.rpc, bad);
                chk(e.tag, "link_reg", link_reg, e.link, bad);
                chk(e.tag, "syndrome_reg", AW'(syndrome_reg), AW'(e.syn), bad);
                chk(e.tag, "saved_state", AW'(saved_state), AW'(e.saved), bad);
                chk(e.tag, "illegal_ret", AW'(illegal_ret), AW'(e.ill), bad);
                n_cmp++;
                if (bad) n_bad++;
            end
        end
    end

    task automatic finish_run;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    endtask

    // Watchdog: a hung run counts as a failed check.
    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            $display("FAIL watchdog: actual running expected finished");
            n_bad++;
            finish_run();
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1;
        tick("R1");                                          // reset state
        vbar_wr_en = 1; vbar_wr_data = 32'h1234_5FFF; tick("R4");
        sync_req = 1; pc_in = 32'h100; cause_in = 16'h00AB; tick("R5");  // D set, still taken
        mask_clr_req = 1; mask_imm = 4'hF; tick("R9");
        serr_req = 1; fiq_req = 1; irq_req = 1; pc_in = 32'h200; cause_in = 16'h00C1; tick("R5");
        serr_req = 0; mask_clr_req = 1; mask_imm = 4'hF; tick("R9");
        pc_in = 32'h300; cause_in = 16'h0777; tick("R8");   // FIQ wins, syndrome kept
        fiq_req = 0; irq_req = 0;
        mask_clr_req = 1; mask_imm = 4'b0100; tick("R9");
        fiq_req = 1; irq_req = 1; tick("R5");               // FIQ masked, IRQ taken
        fiq_req = 0; tick("R6");                            // IRQ held but masked
        irq_req = 0; tick("R13");
        mask_clr_req = 1; mask_imm = 4'b0010; tick("R9");
        sync_req = 1; serr_req = 1; cause_in = 16'h0123; pc_in = 32'h400; tick("R5");
        serr_req = 0;
        mask_clr_req = 1; mask_imm = 4'hF; tick("R9");
        mask_set_req = 1; mask_clr_req = 1; mask_imm = 4'b0101; tick("R9"); // set wins
        eret_req = 1; tick("R10");
        ctx_wr_en = 1; ctx_wr_link = 32'h4000; ctx_wr_state = 7'b0000_0_00; tick("R12");
        eret_req = 1; tick("R10");
        irq_req = 1; el0_narrow = 0; pc_in = 32'h4010; tick("R3");
        irq_req = 0; eret_req = 1; tick("R10");
        sync_req = 1; el0_narrow = 1; pc_in = 32'h4020; cause_in = 16'h0055; tick("R3");
        el0_narrow = 0;
        ctx_wr_en = 1; ctx_wr_link = 32'h5000; ctx_wr_state = 7'b0000_0_01; tick("R12");
        eret_req = 1; tick("R10");                          // same level, stack select 0
        sync_req = 1; pc_in = 32'h5004; tick("R2");
        vbar_wr_en = 1; vbar_wr_data = 32'hFFFF_FFFF; tick("R4");
        sync_req = 1; pc_in = 32'h5008; tick("R2");
        ctx_wr_en = 1; ctx_wr_link = 32'h6000; ctx_wr_state = 7'b0000_0_00; tick("R12");
        eret_req = 1; tick("R10");
        ctx_wr_en = 1; ctx_wr_link = 32'h6100; ctx_wr_state = 7'b0000_1_01; tick("R12");
        eret_req = 1; tick("R11");
        eret_req = 1; ctx_wr_en = 1; ctx_wr_link = 32'h6200; ctx_wr_state = 7'b0000_0_00; tick("R12");
        eret_req = 1; tick("R11");
        ctx_wr_en = 1; ctx_wr_link = 32'h7000; ctx_wr_state = 7'b0001_0_00; tick("R12");
        ctx_wr_en = 1; sync_req = 1; pc_in = 32'h6300; ctx_wr_link = 32'h7700; tick("R12");
        eret_req = 1; tick("R10");
        ctx_wr_en = 1; ctx_wr_link = 32'h7000; ctx_wr_state = 7'b0001_0_00; tick("R12");
        eret_req = 1; mask_set_req = 1; mask_imm = 4'b1000; tick("R9"); // mask ignored on return
        tick("R13");
        done = 1;
        finish_run();
    end
endmodule